// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialisation

This block keeps an asynchronous DRAM refreshed by issuing CAS-before-RAS cycles at a fixed, evenly spread interval. The DRAM's own internal row counter picks the row, so the block produces no address. When a refresh falls due, it raises a request to the access arbiter. Once the arbiter grants it, the block takes the RAS strobe, both CAS byte-lane strobes and the write strobe, and runs the owed cycles back to back. When the debt is cleared, it hands the strobes back.

After reset the block first waits out the power-up pause. It then runs the wake-up refresh cycles without asking for a grant, because no host traffic is allowed yet. Only after that does it raise `mem_ready`. Missed intervals are counted up to a saturating limit, so a long grant delay is made up in a single burst. The arbiter decides when to grant, so a refresh never cuts into a host access that is already running.

The state machine has five states:
- PAUSE: power-up wait. It goes to SETUP when the pause counter expires.
- IDLE: nothing is owed, or the block is waiting for a grant. It goes to SETUP when a cycle is owed and the grant is high.
- SETUP: both CAS lanes are low and RAS is still high. It goes to ACTIVE when the setup count ends.
- ACTIVE: RAS and CAS are both low. It goes to PRECH when the low-time count ends.
- PRECH: all strobes are high. When the count ends, it goes back to SETUP if cycles are still owed, and otherwise to IDLE.

Top module: `rfs_sched`

## Requirements
- R1: While reset is asserted and right after it, `mem_ready` and `rfsh_req` are 0, all strobes are high, and `bus_own` is 1 (the block owns the strobes during initialisation).
- R2: No CAS or RAS strobe goes low until ceil(INIT_US*1000 / CLK_PERIOD_NS) clock cycles after reset is released.
- R3: After the pause, exactly WAKE_CYCLES refresh cycles run without any grant. `mem_ready` then rises, and `rfsh_req` is never high while `mem_ready` is 0.
- R4: In every refresh cycle, both CAS lanes fall together at least ceil(CSR_NS/period) cycles before RAS falls. They stay low for as long as RAS is low. RAS stays low for at least ceil(RAS_NS/period) and ceil(CHR_NS/period) cycles.
- R5: `dram_we_n` is 1 whenever RAS falls and while it is low.
- R6: Between cycles, RAS stays high for at least ceil(RP_NS/period) cycles. CAS stays high for at least ceil(RPC_NS/period) cycles after RAS rises. Successive RAS falls are at least ceil(RC_NS/period) cycles apart.
- R7: A refresh falls due every floor(floor(REFRESH_MS*10^6 / ROWS) / CLK_PERIOD_NS) cycles once ready. The first `rfsh_req` rises exactly that many cycles after `mem_ready`.
- R8: Once raised, `rfsh_req` stays high until granted. Without a grant, `bus_own` is 0 and every strobe stays high.
- R9: Missed intervals add up to at most MAX_DEBT. One grant runs all owed cycles back to back (up to MAX_DEBT), then drops `bus_own` and `rfsh_req`.
- R10: A grant while nothing is owed has no effect: `bus_own` stays 0 and RAS stays high.
- R11: With ROWS=8192 the interval is halved (390 cycles at a 20 ns clock, against 781 for ROWS=4096).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rfsh_gnt | input | 1 | Arbiter grant for the pending refresh |
| rfsh_req | output | 1 | Refresh owed, request to the arbiter |
| bus_own | output | 1 | Block is driving the DRAM strobes |
| mem_ready | output | 1 | Initialisation finished, host access allowed |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_lo_n | output | 1 | Lower byte-lane column strobe, active low |
| dram_cas_hi_n | output | 1 | Upper byte-lane column strobe, active low |
| dram_we_n | output | 1 | Write strobe, held high |

## Verification
The bench builds two instances with a 20 ns clock:
- One uses the default 4096-row count. At this clock the 200 us pause becomes 10,000 cycles and the refresh interval 781 cycles, so the whole initialisation, several intervals and a fully saturated catch-up burst all fit in one short run.
- The other uses 8192 rows and checks that the interval halves.

At 20 ns the nanosecond limits round up to one-cycle setup and precharge and a three-cycle RAS low time. This means every timing floor is exercised at its tightest cycle count.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_PRECH
    } rfs_state_e;

    function automatic int ns_to_cyc(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rfs_tick.sv
module rfs_tick #(
    parameter int LIMIT = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = en && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en)
            cnt <= '0;
        else if (done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rfs_debt.sv
module rfs_debt #(
    parameter int CAP      = 8,
    parameter int LOAD_VAL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic inc,
    input  logic dec,
    output logic empty,
    output logic last
);
    localparam int W = $clog2(CAP + 1);
    localparam logic [W-1:0] CAP_V  = W'(CAP);
    localparam logic [W-1:0] LOAD_V = W'(LOAD_VAL);

    logic [W-1:0] owed;

    assign empty = (owed == '0);
    assign last  = (owed == W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            owed <= '0;
        else if (load)
            owed <= LOAD_V;
        else if (inc && !dec && owed != CAP_V)
            owed <= owed + 1'b1;
        else if (dec && !inc && owed != '0)
            owed <= owed - 1'b1;
    end
endmodule

// File: rtl/rfs_sched.sv
module rfs_sched
    import rfs_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int ROWS          = 4096,
    parameter int REFRESH_MS    = 64,
    parameter int INIT_US       = 200,
    parameter int WAKE_CYCLES   = 8,
    parameter int MAX_DEBT      = 8,
    parameter int CSR_NS        = 5,
    parameter int CHR_NS        = 10,
    parameter int RAS_NS        = 45,
    parameter int RP_NS         = 25,
    parameter int RPC_NS        = 5,
    parameter int RC_NS         = 74
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_gnt,
    output logic rfsh_req,
    output logic bus_own,
    output logic mem_ready,
    output logic dram_ras_n,
    output logic dram_cas_lo_n,
    output logic dram_cas_hi_n,
    output logic dram_we_n
);
    localparam int SU_CYC   = max3(ns_to_cyc(CSR_NS, CLK_PERIOD_NS), 1, 1);
    localparam int ACT_CYC  = max3(ns_to_cyc(RAS_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(CHR_NS, CLK_PERIOD_NS), 1);
    localparam int PRE_CYC  = max3(max3(ns_to_cyc(RPC_NS, CLK_PERIOD_NS), 1, 1),
                                   ns_to_cyc(RP_NS, CLK_PERIOD_NS) - SU_CYC,
                                   ns_to_cyc(RC_NS, CLK_PERIOD_NS) - SU_CYC - ACT_CYC);
    localparam int SLOT_NS  = (REFRESH_MS * 1000000) / ROWS;
    localparam int INTV_CYC = SLOT_NS / CLK_PERIOD_NS;
    localparam int PAUSE_CYC = ns_to_cyc(INIT_US * 1000, CLK_PERIOD_NS);
    localparam int DEBT_CAP = (MAX_DEBT > WAKE_CYCLES) ? MAX_DEBT : WAKE_CYCLES;
    localparam int PH_W     = $clog2(max3(SU_CYC, ACT_CYC, PRE_CYC) + 1);

    rfs_state_e     state, state_d;
    logic [PH_W-1:0] ph, ph_lim;
    logic           ph_end;
    logic           init_q;
    logic           pause_done, tick_done;
    logic           owe_empty, owe_last;
    logic           cyc_end, more, burst_done;

    // power-up pause timer
    rfs_tick #(.LIMIT(PAUSE_CYC)) u_pause (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state == ST_PAUSE),
        .done (pause_done)
    );

    // distributed interval timer, runs once ready
    rfs_tick #(.LIMIT(INTV_CYC)) u_intv (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (!init_q),
        .done (tick_done)
    );

    assign cyc_end    = (state == ST_PRECH) && ph_end;
    assign more       = !owe_last || tick_done;
    assign burst_done = cyc_end && !more;

    rfs_debt #(.CAP(DEBT_CAP), .LOAD_VAL(WAKE_CYCLES)) u_debt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (pause_done),
        .inc  (tick_done),
        .dec  (cyc_end),
        .empty(owe_empty),
        .last (owe_last)
    );

    always_comb begin
        unique case (state)
            ST_SETUP:  ph_lim = PH_W'(SU_CYC - 1);
            ST_ACTIVE: ph_lim = PH_W'(ACT_CYC - 1);
            default:   ph_lim = PH_W'(PRE_CYC - 1);
        endcase
    end
    assign ph_end = (ph == ph_lim);

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_PAUSE:  if (pause_done)              state_d = ST_SETUP;
            ST_IDLE:   if (!owe_empty && rfsh_gnt)  state_d = ST_SETUP;
            ST_SETUP:  if (ph_end)                  state_d = ST_ACTIVE;
            ST_ACTIVE: if (ph_end)                  state_d = ST_PRECH;
            ST_PRECH:  if (ph_end)                  state_d = more ? ST_SETUP : ST_IDLE;
            default:                                state_d = ST_PAUSE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_PAUSE;
            ph     <= '0;
            init_q <= 1'b1;
        end else begin
            state <= state_d;
            if (state_d != state || state == ST_IDLE || state == ST_PAUSE)
                ph <= '0;
            else
                ph <= ph + 1'b1;
            if (burst_done)
                init_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        dram_ras_n    = 1'b1;
        dram_cas_lo_n = 1'b1;
        dram_cas_hi_n = 1'b1;
        bus_own       = 1'b1;
        rfsh_req      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                bus_own  = 1'b0;
                rfsh_req = !owe_empty;
            end
            ST_SETUP: begin
                dram_cas_lo_n = 1'b0;
                dram_cas_hi_n = 1'b0;
            end
            ST_ACTIVE: begin
                dram_ras_n    = 1'b0;
                dram_cas_lo_n = 1'b0;
                dram_cas_hi_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign dram_we_n = 1'b1;
    assign mem_ready = !init_q;
endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk #(
    parameter int CLK_PERIOD_NS = 10,
    parameter int RAS_NS        = 45,
    parameter int WAKE_CYCLES   = 8
) (
    input logic clk,
    input logic rst_n,
    input logic rfsh_gnt,
    input logic rfsh_req,
    input logic bus_own,
    input logic mem_ready,
    input logic dram_ras_n,
    input logic dram_cas_lo_n,
    input logic dram_cas_hi_n,
    input logic dram_we_n
);
    localparam int RAS_MIN = (RAS_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

    logic       ras_q;
    logic [7:0] wake_falls;
    logic [7:0] low_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_q      <= 1'b1;
            wake_falls <= '0;
            low_len    <= '0;
        end else begin
            ras_q <= dram_ras_n;
            if (ras_q && !dram_ras_n && !mem_ready && wake_falls != 8'hFF)
                wake_falls <= wake_falls + 1'b1;
            if (!dram_ras_n && low_len != 8'hFF)
                low_len <= low_len + 1'b1;
            else if (dram_ras_n)
                low_len <= '0;
        end
    end

    p_cas_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_q && !dram_ras_n) |-> ($past(!dram_cas_lo_n) && $past(!dram_cas_hi_n)));

    p_cas_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (!dram_cas_lo_n && !dram_cas_hi_n));

    p_ras_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_q && dram_ras_n) |-> (low_len >= 8'(RAS_MIN)));

    p_we_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> dram_we_n);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_req && !rfsh_gnt) |=> rfsh_req);

    p_quiet_unowned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> (dram_ras_n && dram_cas_lo_n && dram_cas_hi_n));

    p_req_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_req |-> mem_ready);

    p_wake_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ready) |-> (wake_falls == 8'(WAKE_CYCLES)));
endmodule

bind rfs_sched rfs_sched_chk #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .RAS_NS       (RAS_NS),
    .WAKE_CYCLES  (WAKE_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rfsh_gnt     (rfsh_gnt),
    .rfsh_req     (rfsh_req),
    .bus_own      (bus_own),
    .mem_ready    (mem_ready),
    .dram_ras_n   (dram_ras_n),
    .dram_cas_lo_n(dram_cas_lo_n),
    .dram_cas_hi_n(dram_cas_hi_n),
    .dram_we_n    (dram_we_n)
);

// File: tb/rfs_sched_tb.sv
`timescale 1ns/1ps
module rfs_sched_tb;
    localparam int CLK_PERIOD = 20;
    localparam int PAUSE_MIN  = (200 * 1000 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int INTV_4K    = ((64 * 1000000) / 4096) / CLK_PERIOD;
    localparam int INTV_8K    = ((64 * 1000000) / 8192) / CLK_PERIOD;
    localparam int SU_MIN     = (5 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RAS_MIN    = (45 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RP_MIN     = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RPC_MIN    = (5 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RC_MIN     = (74 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int WAKE       = 8;
    localparam int NVEC       = 5;
    // grant delay after request, expected cycles in the burst
    localparam int VEC_DLY [NVEC] = '{10, 900, 1700, 3200, 7100};
    localparam int VEC_EXP [NVEC] = '{1, 2, 3, 5, 8};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic req, own, ready, ras_n, cas_lo_n, cas_hi_n, we_n;
    logic req8, own8, ready8, ras8, casl8, cash8, we8;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rfs_sched #(.CLK_PERIOD_NS(CLK_PERIOD), .ROWS(4096)) u_dut (
        .clk(clk), .rst_n(rst_n), .rfsh_gnt(gnt), .rfsh_req(req),
        .bus_own(own), .mem_ready(ready), .dram_ras_n(ras_n),
        .dram_cas_lo_n(cas_lo_n), .dram_cas_hi_n(cas_hi_n), .dram_we_n(we_n)
    );

    rfs_sched #(.CLK_PERIOD_NS(CLK_PERIOD), .ROWS(8192)) u_dut8k (
        .clk(clk), .rst_n(rst_n), .rfsh_gnt(1'b0), .rfsh_req(req8),
        .bus_own(own8), .mem_ready(ready8), .dram_ras_n(ras8),
        .dram_cas_lo_n(casl8), .dram_cas_hi_n(cash8), .dram_we_n(we8)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // strobe timing monitor
    int  cyc = 0, falls = 0, last_fall = -1;
    int  cas_run = 0, ras_lo_run = 0, ras_hi_run = 0, cas_hi_after = 0;
    bit  prev_ras = 1'b1, prev_cas = 1'b1, seen_rise = 1'b0, hold_bad = 1'b0;
    bit  early_req = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ras = 1'b1; prev_cas = 1'b1; seen_rise = 1'b0;
            cas_run = 0; ras_lo_run = 0; ras_hi_run = 0; cas_hi_after = 0;
            hold_bad = 1'b0; last_fall = -1;
        end else begin
            cyc++;
            if (req && !ready) early_req = 1'b1;
            if (prev_ras && !ras_n) begin
                falls++;
                chk(!cas_lo_n && !cas_hi_n, "R4 lanes low at RAS fall", cas_lo_n + cas_hi_n, 0);
                chk(cas_run >= SU_MIN, "R4 CAS lead", cas_run, SU_MIN);
                chk(we_n == 1'b1, "R5 write strobe at RAS fall", we_n, 1);
                if (seen_rise) chk(ras_hi_run >= RP_MIN, "R6 RAS precharge", ras_hi_run, RP_MIN);
                if (last_fall >= 0) chk(cyc - last_fall >= RC_MIN, "R6 cycle time", cyc - last_fall, RC_MIN);
                last_fall = cyc;
                hold_bad = 1'b0;
            end
            if (!ras_n && (cas_lo_n || cas_hi_n || !we_n)) hold_bad = 1'b1;
            if (!prev_ras && ras_n) begin
                chk(ras_lo_run >= RAS_MIN, "R4 RAS low width", ras_lo_run, RAS_MIN);
                chk(!hold_bad, "R4 CAS held low and R5 write high during RAS low", hold_bad, 0);
                seen_rise = 1'b1;
            end
            if (prev_cas && !cas_lo_n && seen_rise)
                chk(cas_hi_after >= RPC_MIN, "R6 RAS-to-CAS precharge", cas_hi_after, RPC_MIN);
            // run-length bookkeeping
            if (!ras_n) ras_lo_run = prev_ras ? 1 : ras_lo_run + 1;
            if (ras_n) ras_hi_run++; else ras_hi_run = 0;
            if (!cas_lo_n && ras_n) cas_run++; else if (cas_lo_n) cas_run = 0;
            if (ras_n && cas_lo_n) cas_hi_after++; else if (!ras_n) cas_hi_after = 0;
            prev_ras = ras_n;
            prev_cas = cas_lo_n;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    // 8K instance interval (R11)
    initial begin
        int n;
        @(posedge rst_n);
        while (!ready8) @(negedge clk);
        n = 0;
        while (!req8) begin @(negedge clk); n++; end
        chk(n == INTV_8K, "R11 8K interval", n, INTV_8K);
    end

    initial begin
        int n, f0;
        bit held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!ready && !req, "R1 ready/req low in reset", {ready, req}, 0);
        chk(ras_n && cas_lo_n && cas_hi_n && we_n, "R1 strobes high in reset",
            {ras_n, cas_lo_n, cas_hi_n}, 7);
        chk(own == 1'b1, "R1 owns strobes during init", own, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ready && !req && ras_n && cas_lo_n, "R1 quiet after release", ready, 0);

        // R2 pause length
        n = 1;
        while (cas_lo_n && ras_n) begin @(negedge clk); n++; end
        chk(n >= PAUSE_MIN, "R2 power-up pause", n, PAUSE_MIN);

        // R3 wake-up cycles
        f0 = falls;
        while (!ready) @(negedge clk);
        chk(falls - f0 == WAKE, "R3 wake-up cycle count", falls - f0, WAKE);
        chk(!early_req, "R3 no request before ready", early_req, 0);
        chk(!own, "R3 strobes released at ready", own, 0);

        // R7 first interval
        n = 0;
        while (!req) begin @(negedge clk); n++; end
        chk(n == INTV_4K, "R7 refresh interval", n, INTV_4K);

        // table: grant delay against expected catch-up burst (R8, R9)
        for (int v = 0; v < NVEC; v++) begin
            while (!req) @(negedge clk);
            held = 1'b1;
            for (int d = 0; d < VEC_DLY[v]; d++) begin
                @(negedge clk);
                if (!req || own || !cas_lo_n || !ras_n) held = 1'b0;
            end
            chk(held, "R8 request held, strobes idle until grant", held, 1);
            f0 = falls;
            gnt = 1'b1;
            @(negedge clk);
            gnt = 1'b0;
            chk(own, "R9 strobes taken after grant", own, 1);
            while (own) @(negedge clk);
            chk(falls - f0 == VEC_EXP[v], "R9 catch-up burst length", falls - f0, VEC_EXP[v]);
            chk(!req, "R9 request dropped after burst", req, 0);
        end

        // R10 grant with nothing owed
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        held = 1'b1;
        for (int d = 0; d < 6; d++) begin
            @(negedge clk);
            if (own || !ras_n || !cas_lo_n) held = 1'b0;
        end
        chk(held, "R10 spurious grant ignored", held, 1);

        // R1 reset during operation
        rst_n = 1'b0;
        @(negedge clk);
        chk(!ready && !req && ras_n && cas_lo_n && own, "R1 mid-run reset", ready, 0);
        finish_run();
    end
endmodule